// File: doc/BRIEF.md
# Microstep Position Counter for One Step/Direction Axis

This block turns a pulse-train motor command into a position inside one electrical cycle of a two-phase stepper. An external controller toggles a step line and holds a direction line. The block brings both lines into its clock domain and finds the active step edges. On each accepted edge it moves a 10-bit position forward or back. A sine/cosine lookup stage downstream reads that position.

The distance moved on each step depends on the selected microstep resolution, so one full step always covers the same part of the cycle. A mode input chooses whether only rising step edges count or both edges count. Counting on both edges halves the toggle rate needed on slow or isolated links. An enable input gates acceptance of steps. Each accepted step also produces a one-cycle event pulse for downstream logic.

Top module: `step_pos_counter`

## Requirements
- R1: While reset is asserted and right after it is released, `position` is 0 and `step_pulse` is 0.
- R2: With `dual_edge` = 0, only a rising edge on `step_in` is a step; a falling edge produces no pulse and leaves `position` unchanged.
- R3: With `dual_edge` = 1, both rising and falling edges on `step_in` are steps.
- R4: The level of `dir_in` at the step edge sets the direction: 0 adds the increment to `position`, 1 subtracts it.
- R5: For `res_sel` codes 0 to 7 the increment is 2 to the power of the code (code 0 = 256 microsteps per full step, increment 1; code 7 = 2 microsteps, increment 128).
- R6: Any `res_sel` code of 8 or more selects full-step mode. The top two bits of `position` move by one in the step direction, and the low eight bits become 128 (both coils carry equal current).
- R7: While `enable` is 0, step edges are ignored: there is no pulse and `position` holds. Re-enabling produces no step for edges seen while disabled.
- R8: Each accepted step gives `step_pulse` high for exactly one cycle, in the same cycle as the updated `position`. The update appears on the third rising clock edge after `step_in` changes, through two synchroniser stages and the counter register.
- R9: `position` wraps modulo 1024 in both directions (0 minus 1 gives 1023).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_in | input | 1 | Asynchronous step command line |
| dir_in | input | 1 | Asynchronous direction line, 0 = forward |
| dual_edge | input | 1 | 1 = count both step edges, 0 = rising only |
| res_sel | input | 4 | Resolution code, 0..7 microstep, 8+ full step |
| enable | input | 1 | 1 = accept steps |
| position | output | 10 | Position within one electrical cycle |
| step_pulse | output | 1 | One-cycle strobe per accepted step |

## Verification
The bench steps through the cycle boundaries in both directions. A counter that saturates or drops the carry would stick at 0 or 1023, or jump to the wrong place, at the wrap. It toggles falling edges in single-edge mode and toggles the step line while the axis is disabled. A design that counts the wrong edge or remembers a gated edge would then emit a stray pulse that the scoreboard has no item for. Full-step mode is entered from an unaligned position and run backwards across zero. This catches a design that adds 256 without forcing the 128 offset, or that treats out-of-range codes as microstep codes. The pulse is sampled at the exact third edge, so an extra or missing pipeline stage shows up as a latency failure.

// File: rtl/step_pos_pkg.sv
package step_pos_pkg;

  typedef enum logic {
    DIR_FWD = 1'b0,
    DIR_REV = 1'b1
  } step_dir_e;

endpackage

// File: rtl/sp_sync.sv
module sp_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] stage_d [STAGES];

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_comb stage_d[gi] = async_i;
      end else begin : g_next
        always_comb stage_d[gi] = stage_q[gi-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[gi] <= '0;
        else        stage_q[gi] <= stage_d[gi];
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/sp_edge_detect.sv
module sp_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic step_s,
  input  logic dual_edge,
  output logic step_evt
);

  logic prev_q;
  logic prev_d;

  always_comb begin
    prev_d   = step_s;
    step_evt = dual_edge ? (step_s ^ prev_q) : (step_s & ~prev_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

endmodule

// File: rtl/sp_pos_core.sv
module sp_pos_core
  import step_pos_pkg::*;
#(
  parameter int POS_W = 10,
  parameter int RES_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_evt,
  input  logic             dir_s,
  input  logic             enable,
  input  logic [RES_W-1:0] res_sel,
  output logic [POS_W-1:0] position,
  output logic             step_pulse
);

  localparam int               FULL_CODE = POS_W - 2;
  localparam logic [RES_W-1:0] FULL_SEL  = RES_W'(FULL_CODE);
  localparam logic [POS_W-3:0] FS_LOW    = {1'b1, {(POS_W-3){1'b0}}};
  localparam logic [POS_W-1:0] ONE       = {{(POS_W-1){1'b0}}, 1'b1};

  logic [POS_W-1:0] pos_q, pos_d;
  logic             pulse_q, pulse_d;
  logic             accept;
  logic             full_mode;
  logic [POS_W-1:0] inc;
  logic [1:0]       quad;
  step_dir_e        dir_e;

  always_comb begin
    dir_e     = step_dir_e'(dir_s);
    accept    = step_evt & enable;
    full_mode = (res_sel >= FULL_SEL);
    inc       = full_mode ? '0 : (ONE << res_sel);
    quad      = (dir_e == DIR_FWD) ? pos_q[POS_W-1 -: 2] + 2'd1
                                   : pos_q[POS_W-1 -: 2] - 2'd1;
    pos_d     = pos_q;
    if (accept) begin
      if (full_mode)             pos_d = {quad, FS_LOW};
      else if (dir_e == DIR_FWD) pos_d = pos_q + inc;
      else                       pos_d = pos_q - inc;
    end
    pulse_d = accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      if (accept) pos_q <= pos_d;
      pulse_q <= pulse_d;
    end
  end

  assign position   = pos_q;
  assign step_pulse = pulse_q;

  // R7 / R8: position only moves together with the step strobe
  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pulse_q |-> $stable(pos_q));

  // R7: a disabled cycle never yields a strobe
  p_disabled_no_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(enable) |-> !pulse_q);

  // R6: full-step landings sit on the equal-current offset
  p_fullstep_offset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_q && ($past(res_sel) >= FULL_SEL)) |-> (pos_q[POS_W-3:0] == FS_LOW));

  // R5: microstep moves have exactly the selected magnitude
  p_step_size_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_q && ($past(res_sel) < FULL_SEL)) |->
      (((pos_q - $past(pos_q)) == (ONE << $past(res_sel))) ||
       (($past(pos_q) - pos_q) == (ONE << $past(res_sel)))));

endmodule

// File: rtl/step_pos_counter.sv
module step_pos_counter #(
  parameter int POS_W       = 10,
  parameter int RES_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_in,
  input  logic             dir_in,
  input  logic             dual_edge,
  input  logic [RES_W-1:0] res_sel,
  input  logic             enable,
  output logic [POS_W-1:0] position,
  output logic             step_pulse
);

  logic [1:0] raw_in;
  logic [1:0] sync_out;
  logic       step_s;
  logic       dir_s;
  logic       step_evt;

  assign raw_in = {dir_in, step_in};
  assign step_s = sync_out[0];
  assign dir_s  = sync_out[1];

  sp_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (raw_in),
    .sync_o  (sync_out)
  );

  sp_edge_detect u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_s    (step_s),
    .dual_edge (dual_edge),
    .step_evt  (step_evt)
  );

  sp_pos_core #(.POS_W(POS_W), .RES_W(RES_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_evt   (step_evt),
    .dir_s      (dir_s),
    .enable     (enable),
    .res_sel    (res_sel),
    .position   (position),
    .step_pulse (step_pulse)
  );

  // R2: in single-edge mode a strobe needs a synchronised rising edge two cycles earlier
  p_rise_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_pulse && !$past(dual_edge)) |-> ($past(step_s) && !$past(step_s, 2)));

endmodule

// File: tb/step_pos_counter_tb.sv
module step_pos_counter_tb;

  logic       clk;
  logic       rst_n;
  logic       step_in;
  logic       dir_in;
  logic       dual_edge;
  logic [3:0] res_sel;
  logic       enable;
  logic [9:0] position;
  logic       step_pulse;

  int n_cmp;
  int n_bad;
  logic [9:0] exp_pos;
  logic [9:0] exp_q [$];

  step_pos_counter u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_in    (step_in),
    .dir_in     (dir_in),
    .dual_edge  (dual_edge),
    .res_sel    (res_sel),
    .enable     (enable),
    .position   (position),
    .step_pulse (step_pulse)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [9:0] model_next(input logic [9:0] p, input logic d,
                                             input logic [3:0] code);
    logic [1:0] q;
    if (code >= 4'd8) begin
      q = d ? p[9:8] - 2'd1 : p[9:8] + 2'd1;
      return {q, 8'd128};
    end
    return d ? p - (10'd1 << code) : p + (10'd1 << code);
  endfunction

  // monitor: pops one expected position per strobe
  always @(negedge clk) begin
    if (rst_n && step_pulse) begin
      if (exp_q.size() == 0) begin
        n_cmp++;
        n_bad++;
        $display("FAIL R8: actual unexpected strobe at %0d expected none", position);
      end else begin
        check("R4/R5/R6/R9 position", 32'(position), 32'(exp_q.pop_front()));
      end
    end
  end

  // driver: sets direction, moves step line, pushes expectation, checks latency
  task automatic drive_step(input logic lvl, input logic d, input string req);
    logic acc;
    @(negedge clk);
    dir_in = d;
    @(negedge clk);
    step_in = lvl;
    acc = enable && (dual_edge || lvl);
    if (acc) begin
      exp_pos = model_next(exp_pos, d, res_sel);
      exp_q.push_back(exp_pos);
    end
    repeat (2) @(negedge clk);
    check({req, " no early strobe R8"}, 32'(step_pulse), 32'd0);
    @(negedge clk);
    check({req, " strobe at third edge R8"}, 32'(step_pulse), 32'(acc));
    @(negedge clk);
    check({req, " strobe one cycle R8"}, 32'(step_pulse), 32'd0);
    check({req, " held position"}, 32'(position), 32'(exp_pos));
  endtask

  task automatic full_step(input logic d, input string req);
    drive_step(1'b1, d, req);
    drive_step(1'b0, d, req);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    n_cmp = 0; n_bad = 0; exp_pos = '0;
    rst_n = 1'b0; step_in = 1'b0; dir_in = 1'b0;
    dual_edge = 1'b0; res_sel = 4'd0; enable = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset position", 32'(position), 32'd0);
    check("R1 reset strobe", 32'(step_pulse), 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after release", 32'(position), 32'd0);

    // R2 / R4 / R5: rising edges only, finest resolution, forward
    for (int i = 0; i < 3; i++) full_step(1'b0, "R2 fwd");
    check("R4 fwd total", 32'(position), 32'd3);
    // R4 / R9: reverse through zero
    for (int i = 0; i < 4; i++) full_step(1'b1, "R4 rev");
    check("R9 wrap down", 32'(position), 32'd1023);
    // R5 / R9: increment 8 wraps upward
    res_sel = 4'd3;
    full_step(1'b0, "R5 code3");
    check("R9 wrap up", 32'(position), 32'd7);
    // R3: both edges with increment 128
    dual_edge = 1'b1; res_sel = 4'd7;
    drive_step(1'b1, 1'b0, "R3 rise");
    drive_step(1'b0, 1'b0, "R3 fall");
    check("R3 two steps", 32'(position), 32'd263);
    // R6: full step from unaligned position, code 8 and clamped code 12
    res_sel = 4'd8;
    drive_step(1'b1, 1'b0, "R6 fwd");
    check("R6 fwd landing", 32'(position), 32'd640);
    drive_step(1'b0, 1'b1, "R6 rev");
    check("R6 rev landing", 32'(position), 32'd384);
    res_sel = 4'd12;
    drive_step(1'b1, 1'b1, "R6 clamp");
    drive_step(1'b0, 1'b1, "R6 clamp wrap");
    check("R6 wrap landing", 32'(position), 32'd896);
    // R7: disabled edges ignored, no phantom on re-enable
    enable = 1'b0;
    drive_step(1'b1, 1'b0, "R7 gated rise");
    drive_step(1'b0, 1'b0, "R7 gated fall");
    drive_step(1'b1, 1'b0, "R7 gated rise2");
    check("R7 held while disabled", 32'(position), 32'd896);
    @(negedge clk);
    enable = 1'b1;
    repeat (4) @(negedge clk);
    check("R7 no phantom", 32'(position), 32'd896);
    res_sel = 4'd0;
    drive_step(1'b0, 1'b0, "R7 resumed");
    check("R7 resumed step", 32'(position), 32'd897);

    repeat (4) @(negedge clk);
    check("R8 all strobes seen", 32'(exp_q.size()), 32'd0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule